// File: doc/BRIEF.md
# Multi-Plane Flash Operation Scheduler

This block is the behavioural core of a flash memory model whose array is split into four planes. It accepts one decoded command per cycle (read, program, erase, suspend, resume, read-reset) together with a two-bit programming-voltage level. It runs at most one program or erase at a time, and a countdown replaces the analog programming time. While that operation runs, reads to every other plane return array data. A read aimed at the busy plane returns a status word carrying a data-polling bit and a toggle bit.

A running operation can be parked with a suspend command and continued later with a resume command. While it is parked, any plane can be read and a program can be started in any plane other than the parked one. The array is a small register memory. Reset fills it with ones, which is the erased value. A program clears bits: the new word is the old word ANDed with the data. An erase sets every word of one plane back to all ones, so the erase unit is the whole plane.

Top module: `flash_plane_sched`

## Requirements
- R1: After reset no plane is busy, `status_o` equals 8'h80 and every array word reads 8'hFF.
- R2: A read command (`cmd_op_i` = 0) to a plane without a running operation returns that word one cycle later on `rd_data_o`, with `rd_valid_o` and `arr_rd_o` high for that single cycle. This holds while another plane is busy.
- R3: A read to the plane with the running operation returns the status word and leaves `arr_rd_o` low. The status word has bit 7 = polling, bit 6 = toggle, bit 5 = an operation is suspended, bit 4 = an operation is running, and bits 3..0 = 0. Polling is the complement of bit 7 of the word the operation will leave behind, and it is 1 when nothing runs. Toggle is cleared when an operation starts and flips after every status read.
- R4: A program (`cmd_op_i` = 1) sets the word to old AND data. An erase (`cmd_op_i` = 2) sets every word of the plane to 8'hFF. With `vpp_lvl_i` = 2'b01 the plane is busy for T_PROG or T_ERASE cycles. With `vpp_lvl_i[1]` = 1 it is busy for T_PROG_FAST or T_ERASE_FAST cycles. `arr_wr_o` is high in the last busy cycle.
- R5: With `vpp_lvl_i` = 2'b00, program and erase commands are ignored. The level is sampled only when a command is accepted.
- R6: At most one plane is busy. A program or erase issued while an operation runs is ignored.
- R7: A suspend command (`cmd_op_i` = 3) stops the running operation: the plane drops busy and status bit 5 rises. The cycle that carries the suspend counts as worked. After a resume (`cmd_op_i` = 4), the plane is busy again for exactly the remaining cycles, so the total busy time equals the unsuspended duration.
- R8: While an operation is suspended, reads to any plane return array data, and a program to another plane runs normally. A program to the suspended plane, an erase, and a second suspend are all ignored.
- R9: A resume is ignored when nothing is suspended or while an operation runs.
- R10: A read-reset command (`cmd_op_i` = 5) has no effect: it produces no read response, a running operation continues, and the status word is unchanged.
- R11: When an operation completes, its plane returns to read mode: reads return the updated data and status bit 4 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Opcode: 0 read, 1 program, 2 erase, 3 suspend, 4 resume, 5 read-reset |
| cmd_plane_i | input | 2 | Target plane |
| cmd_addr_i | input | 2 | Word within the plane |
| cmd_data_i | input | 8 | Program data |
| vpp_lvl_i | input | 2 | Voltage level: 00 inhibit, 01 normal, 1x high |
| plane_busy_o | output | 4 | One bit per plane, high while its operation runs |
| status_o | output | 8 | Live status word |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 8 | Read response: array word or status word |
| arr_rd_o | output | 1 | Response came from the array |
| arr_wr_o | output | 1 | Array update at the end of this cycle |

## Verification
A stuck or lost countdown shows as a busy flag whose length differs from the nominal duration. The bench measures that length per plane, so such a fault appears by the end of the operation. A wrong suspended slot shows as one of two faults. Either the resumed busy time does not add up to the full duration, or the read after completion returns the wrong word. Both appear within a few cycles of the resume. A misrouted read or a toggle that fails to flip shows on the very next response, which the scoreboard compares one cycle after the command.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_SUSP   = 3'd3,
    OP_RESUME = 3'd4,
    OP_RDRST  = 3'd5
  } op_e;

  // status bit offsets from the MSB
  localparam int ST_POLL = 0;
  localparam int ST_TOG  = 1;
  localparam int ST_SUS  = 2;
  localparam int ST_ACT  = 3;
endpackage

// File: rtl/fps_array.sv
module fps_array #(
  parameter int PLANES = 4,
  parameter int WORDS  = 4,
  parameter int DW     = 8,
  localparam int PW    = $clog2(PLANES),
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] rd_plane_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_word_o,
  input  logic          wr_i,
  input  logic          er_i,
  input  logic [PW-1:0] wr_plane_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i
);
  logic [DW-1:0] pl_rd [PLANES];

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [DW-1:0] words [WORDS];
    logic sel;
    assign sel = (wr_plane_i == PW'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < WORDS; w++) words[w] <= '1;
      end else if (er_i && sel) begin
        for (int w = 0; w < WORDS; w++) words[w] <= '1;
      end else if (wr_i && sel) begin
        words[wr_addr_i] <= words[wr_addr_i] & wr_data_i;
      end
    end

    assign pl_rd[p] = words[rd_addr_i];
  end

  assign rd_word_o = pl_rd[rd_plane_i];
endmodule

// File: rtl/fps_op_ctrl.sv
module fps_op_ctrl
  import fps_pkg::*;
#(
  parameter int PLANES       = 4,
  parameter int WORDS        = 4,
  parameter int DW           = 8,
  parameter int T_PROG       = 8,
  parameter int T_PROG_FAST  = 3,
  parameter int T_ERASE      = 40,
  parameter int T_ERASE_FAST = 12,
  localparam int PW   = $clog2(PLANES),
  localparam int AW   = $clog2(WORDS),
  localparam int TMAX = (T_ERASE > T_PROG) ? T_ERASE : T_PROG,
  localparam int CW   = $clog2(TMAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [PW-1:0] cmd_plane_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic [1:0]    vpp_lvl_i,
  input  logic [DW-1:0] cur_word_i,
  output logic          act_v_o,
  output logic [PW-1:0] act_plane_o,
  output logic          poll_o,
  output logic          sus_v_o,
  output logic          start_o,
  output logic          wr_o,
  output logic          er_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  typedef struct packed {
    logic [PW-1:0] plane;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          erase;
    logic [CW-1:0] cnt;
    logic          bit7;
  } op_t;

  op_t  act_q, sus_q;
  logic act_v_q, sus_v_q;
  logic vpp_ok, fast, done;
  logic start_prog, start_erase, do_susp, do_resume;

  assign vpp_ok = (vpp_lvl_i != 2'b00);
  assign fast   = vpp_lvl_i[1];
  assign done   = act_v_q && (act_q.cnt == CW'(1));

  assign start_prog  = cmd_valid_i && (cmd_op_i == OP_PROG) && vpp_ok && !act_v_q &&
                       !(sus_v_q && (sus_q.plane == cmd_plane_i));
  assign start_erase = cmd_valid_i && (cmd_op_i == OP_ERASE) && vpp_ok && !act_v_q && !sus_v_q;
  assign do_susp     = cmd_valid_i && (cmd_op_i == OP_SUSP) && act_v_q && !sus_v_q && !done;
  assign do_resume   = cmd_valid_i && (cmd_op_i == OP_RESUME) && sus_v_q && !act_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_v_q <= 1'b0;
      sus_v_q <= 1'b0;
      act_q   <= '0;
      sus_q   <= '0;
    end else begin
      if (done) begin
        act_v_q <= 1'b0;
      end else if (act_v_q) begin
        act_q.cnt <= act_q.cnt - CW'(1);
        if (do_susp) begin
          // suspend cycle counts as worked
          sus_q     <= act_q;
          sus_q.cnt <= act_q.cnt - CW'(1);
          sus_v_q   <= 1'b1;
          act_v_q   <= 1'b0;
        end
      end
      if (start_prog) begin
        act_v_q <= 1'b1;
        act_q   <= '{plane: cmd_plane_i, addr: cmd_addr_i, data: cmd_data_i, erase: 1'b0,
                     cnt: fast ? CW'(T_PROG_FAST) : CW'(T_PROG),
                     bit7: cur_word_i[DW-1] & cmd_data_i[DW-1]};
      end else if (start_erase) begin
        act_v_q <= 1'b1;
        act_q   <= '{plane: cmd_plane_i, addr: cmd_addr_i, data: '1, erase: 1'b1,
                     cnt: fast ? CW'(T_ERASE_FAST) : CW'(T_ERASE), bit7: 1'b1};
      end else if (do_resume) begin
        act_v_q <= 1'b1;
        act_q   <= sus_q;
        sus_v_q <= 1'b0;
      end
    end
  end

  assign act_v_o     = act_v_q;
  assign act_plane_o = act_q.plane;
  assign poll_o      = ~act_q.bit7;
  assign sus_v_o     = sus_v_q;
  assign start_o     = start_prog | start_erase;
  assign wr_o        = done && !act_q.erase;
  assign er_o        = done && act_q.erase;
  assign wr_addr_o   = act_q.addr;
  assign wr_data_o   = act_q.data;
endmodule

// File: rtl/fps_rd_path.sv
module fps_rd_path
  import fps_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int DW     = 8,
  localparam int PW    = $clog2(PLANES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic [PW-1:0] rd_plane_i,
  input  logic [DW-1:0] word_i,
  input  logic          act_v_i,
  input  logic [PW-1:0] act_plane_i,
  input  logic          poll_i,
  input  logic          sus_v_i,
  input  logic          start_i,
  output logic [DW-1:0] status_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          arr_rd_o
);
  logic tog_q, hit;

  always_comb begin
    status_o                = '0;
    status_o[DW-1-ST_POLL]  = act_v_i ? poll_i : 1'b1;
    status_o[DW-1-ST_TOG]   = tog_q;
    status_o[DW-1-ST_SUS]   = sus_v_i;
    status_o[DW-1-ST_ACT]   = act_v_i;
  end

  assign hit = act_v_i && (rd_plane_i == act_plane_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      arr_rd_o   <= 1'b0;
      rd_data_o  <= '0;
      tog_q      <= 1'b0;
    end else begin
      rd_valid_o <= rd_req_i;
      arr_rd_o   <= rd_req_i && !hit;
      if (rd_req_i) rd_data_o <= hit ? status_o : word_i;
      if (start_i)              tog_q <= 1'b0;
      else if (rd_req_i && hit) tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/flash_plane_sched.sv
module flash_plane_sched
  import fps_pkg::*;
#(
  parameter int PLANES       = 4,
  parameter int WORDS        = 4,
  parameter int DW           = 8,
  parameter int T_PROG       = 8,
  parameter int T_PROG_FAST  = 3,
  parameter int T_ERASE      = 40,
  parameter int T_ERASE_FAST = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  logic [2:0]                 cmd_op_i,
  input  logic [$clog2(PLANES)-1:0]  cmd_plane_i,
  input  logic [$clog2(WORDS)-1:0]   cmd_addr_i,
  input  logic [DW-1:0]              cmd_data_i,
  input  logic [1:0]                 vpp_lvl_i,
  output logic [PLANES-1:0]          plane_busy_o,
  output logic [DW-1:0]              status_o,
  output logic                       rd_valid_o,
  output logic [DW-1:0]              rd_data_o,
  output logic                       arr_rd_o,
  output logic                       arr_wr_o
);
  localparam int PW = $clog2(PLANES);
  localparam int AW = $clog2(WORDS);

  logic          act_v, poll, sus_v, start, wr, er;
  logic [PW-1:0] act_plane, wr_plane;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, cur_word;
  logic          rd_req;

  assign rd_req   = cmd_valid_i && (cmd_op_i == OP_READ);
  assign wr_plane = act_plane;

  fps_array #(.PLANES(PLANES), .WORDS(WORDS), .DW(DW)) u_array (
    .clk_i, .rst_ni,
    .rd_plane_i(cmd_plane_i), .rd_addr_i(cmd_addr_i), .rd_word_o(cur_word),
    .wr_i(wr), .er_i(er), .wr_plane_i(wr_plane), .wr_addr_i(wr_addr), .wr_data_i(wr_data)
  );

  fps_op_ctrl #(
    .PLANES(PLANES), .WORDS(WORDS), .DW(DW), .T_PROG(T_PROG), .T_PROG_FAST(T_PROG_FAST),
    .T_ERASE(T_ERASE), .T_ERASE_FAST(T_ERASE_FAST)
  ) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_plane_i, .cmd_addr_i, .cmd_data_i,
    .vpp_lvl_i, .cur_word_i(cur_word),
    .act_v_o(act_v), .act_plane_o(act_plane), .poll_o(poll), .sus_v_o(sus_v),
    .start_o(start), .wr_o(wr), .er_o(er), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  fps_rd_path #(.PLANES(PLANES), .DW(DW)) u_rd (
    .clk_i, .rst_ni, .rd_req_i(rd_req), .rd_plane_i(cmd_plane_i), .word_i(cur_word),
    .act_v_i(act_v), .act_plane_i(act_plane), .poll_i(poll), .sus_v_i(sus_v),
    .start_i(start), .status_o, .rd_valid_o, .rd_data_o, .arr_rd_o
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_busy
    assign plane_busy_o[p] = act_v && (act_plane == PW'(p));
  end

  assign arr_wr_o = wr | er;
endmodule

// File: rtl/fps_sva.sv
module fps_sva
  import fps_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int WORDS  = 4,
  parameter int DW     = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cmd_valid_i,
  input logic [2:0]                cmd_op_i,
  input logic [$clog2(PLANES)-1:0] cmd_plane_i,
  input logic [$clog2(WORDS)-1:0]  cmd_addr_i,
  input logic [DW-1:0]             cmd_data_i,
  input logic [1:0]                vpp_lvl_i,
  input logic [PLANES-1:0]         plane_busy_o,
  input logic [DW-1:0]             status_o,
  input logic                      rd_valid_o,
  input logic [DW-1:0]             rd_data_o,
  input logic                      arr_rd_o,
  input logic                      arr_wr_o
);
  logic sus_bit;
  assign sus_bit = status_o[DW-1-ST_SUS];

  assert_busy_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(plane_busy_o));

  assert_vpp_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == OP_PROG || cmd_op_i == OP_ERASE) && vpp_lvl_i == 2'b00 &&
     plane_busy_o == '0) |=> (plane_busy_o == '0));

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_o |=> (plane_busy_o == '0));

  assert_rd_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(cmd_valid_i && cmd_op_i == OP_READ));

  assert_arr_rd_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rd_o |-> rd_valid_o);

  assert_suspend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_SUSP && plane_busy_o != '0 && !sus_bit && !arr_wr_o)
    |=> (plane_busy_o == '0 && sus_bit));

  assert_resume_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_RESUME && !sus_bit && plane_busy_o == '0)
    |=> (plane_busy_o == '0));

  assert_idle_poll_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plane_busy_o == '0) |-> status_o[DW-1-ST_POLL]);
endmodule

bind flash_plane_sched fps_sva #(.PLANES(PLANES), .WORDS(WORDS), .DW(DW)) u_sva (.*);

// File: tb/flash_plane_sched_test.sv
module flash_plane_sched_test;
  import fps_pkg::*;
  localparam int TCLK = 10;
  localparam int TP = 8, TPF = 3, TE = 40, TEF = 12;

  logic       clk = 0, rst_n = 0;
  logic       cmd_valid_i = 0;
  logic [2:0] cmd_op_i = 0;
  logic [1:0] cmd_plane_i = 0, cmd_addr_i = 0, vpp_lvl_i = 2'b01;
  logic [7:0] cmd_data_i = 0;
  logic [3:0] plane_busy_o;
  logic [7:0] status_o, rd_data_o;
  logic       rd_valid_o, arr_rd_o, arr_wr_o;

  int total = 0, bad = 0, cyc = 0, wcnt = 0;
  int bcyc [4];
  logic [7:0] exp_q [$];
  logic       arr_q [$];
  string      tag_q [$];

  always #(TCLK/2) clk = ~clk;

  flash_plane_sched #(.T_PROG(TP), .T_PROG_FAST(TPF), .T_ERASE(TE), .T_ERASE_FAST(TEF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i, .cmd_op_i, .cmd_plane_i, .cmd_addr_i,
    .cmd_data_i, .vpp_lvl_i, .plane_busy_o, .status_o, .rd_valid_o, .rd_data_o,
    .arr_rd_o, .arr_wr_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected read response", 1, 0);
      else begin
        logic [7:0] e; logic a; string t;
        e = exp_q.pop_front(); a = arr_q.pop_front(); t = tag_q.pop_front();
        chk(rd_data_o == e, t, rd_data_o, e);
        chk(arr_rd_o == a, {t, " arr_rd"}, arr_rd_o, a);
      end
    end
    for (int p = 0; p < 4; p++) if (plane_busy_o[p]) bcyc[p]++;
    if (arr_wr_o) wcnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cmd(input logic [2:0] op, input int pl, input int ad,
                     input logic [7:0] d, input logic [1:0] v);
    cmd_valid_i = 1; cmd_op_i = op; cmd_plane_i = 2'(pl); cmd_addr_i = 2'(ad);
    cmd_data_i = d; vpp_lvl_i = v;
    @(negedge clk);
    cmd_valid_i = 0;
  endtask

  task automatic rd(input int pl, input int ad, input logic [7:0] e, input logic a,
                    input string tag);
    exp_q.push_back(e); arr_q.push_back(a); tag_q.push_back(tag);
    cmd(OP_READ, pl, ad, 8'h00, 2'b01);
  endtask

  task automatic wait_idle();
    while (plane_busy_o != 4'b0000) @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) bcyc[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(plane_busy_o == 0, "R1 busy after reset", plane_busy_o, 0);
    chk(status_o == 8'h80, "R1 status after reset", status_o, 8'h80);
    rd(0, 0, 8'hFF, 1, "R1 erased p0a0");
    rd(3, 3, 8'hFF, 1, "R1 erased p3a3");

    // normal program, status reads, concurrent read
    bcyc[1] = 0; wcnt = 0;
    cmd(OP_PROG, 1, 2, 8'h5A, 2'b01);
    chk(plane_busy_o == 4'b0010, "R4 busy p1", plane_busy_o, 4'b0010);
    rd(1, 2, 8'h90, 0, "R3 status toggle 0");
    rd(1, 2, 8'hD0, 0, "R3 status toggle 1");
    rd(0, 0, 8'hFF, 1, "R2 read idle plane");
    wait_idle();
    chk(bcyc[1] == TP, "R4 program cycles", bcyc[1], TP);
    chk(wcnt == 1, "R4 arr_wr pulse", wcnt, 1);
    chk(status_o == 8'h80, "R11 status after done", status_o, 8'h80);
    rd(1, 2, 8'h5A, 1, "R11 program result");

    // fast program, AND semantics
    bcyc[1] = 0;
    cmd(OP_PROG, 1, 2, 8'h0F, 2'b10);
    wait_idle();
    chk(bcyc[1] == TPF, "R4 fast program cycles", bcyc[1], TPF);
    rd(1, 2, 8'h0A, 1, "R4 program ANDs");

    // inhibit
    cmd(OP_PROG, 2, 0, 8'h00, 2'b00);
    chk(plane_busy_o == 0, "R5 program inhibited", plane_busy_o, 0);
    cmd(OP_ERASE, 1, 0, 8'h00, 2'b00);
    chk(plane_busy_o == 0, "R5 erase inhibited", plane_busy_o, 0);
    rd(2, 0, 8'hFF, 1, "R5 p2 untouched");
    rd(1, 2, 8'h0A, 1, "R5 p1 untouched");

    // erase with second command refused
    bcyc[1] = 0;
    cmd(OP_ERASE, 1, 0, 8'h00, 2'b01);
    rd(1, 0, 8'h10, 0, "R3 erase status");
    cmd(OP_PROG, 2, 1, 8'h33, 2'b01);
    chk(plane_busy_o == 4'b0010, "R6 second op refused", plane_busy_o, 4'b0010);
    rd(1, 0, 8'h50, 0, "R3 erase status toggled");
    wait_idle();
    chk(bcyc[1] == TE, "R4 erase cycles", bcyc[1], TE);
    rd(1, 2, 8'hFF, 1, "R4 erase result");
    rd(2, 1, 8'hFF, 1, "R6 refused program left data");

    // suspend / resume
    bcyc[0] = 0; bcyc[2] = 0;
    cmd(OP_PROG, 0, 1, 8'h3C, 2'b01);
    rd(3, 0, 8'hFF, 1, "R2 read during program");
    rd(3, 1, 8'hFF, 1, "R2 read during program");
    cmd(OP_SUSP, 0, 0, 8'h00, 2'b01);
    chk(plane_busy_o == 0, "R7 suspend clears busy", plane_busy_o, 0);
    chk(status_o == 8'hA0, "R7 suspend status", status_o, 8'hA0);
    rd(0, 1, 8'hFF, 1, "R8 read suspended plane");
    cmd(OP_PROG, 0, 2, 8'h00, 2'b01);
    chk(plane_busy_o == 0, "R8 program to suspended plane ignored", plane_busy_o, 0);
    cmd(OP_PROG, 2, 0, 8'h77, 2'b10);
    chk(plane_busy_o == 4'b0100, "R8 program other plane", plane_busy_o, 4'b0100);
    cmd(OP_RESUME, 0, 0, 8'h00, 2'b01);
    chk(plane_busy_o == 4'b0100, "R9 resume ignored while active", plane_busy_o, 4'b0100);
    wait_idle();
    chk(bcyc[2] == TPF, "R8 program during suspend cycles", bcyc[2], TPF);
    chk(status_o == 8'hA0, "R9 still suspended", status_o, 8'hA0);
    cmd(OP_ERASE, 2, 0, 8'h00, 2'b01);
    chk(plane_busy_o == 0, "R8 erase during suspend ignored", plane_busy_o, 0);
    rd(2, 0, 8'h77, 1, "R8 program during suspend data");
    cmd(OP_RESUME, 0, 0, 8'h00, 2'b01);
    chk(plane_busy_o == 4'b0001, "R7 resume busy", plane_busy_o, 4'b0001);
    wait_idle();
    chk(bcyc[0] == TP, "R7 total busy across suspend", bcyc[0], TP);
    rd(0, 1, 8'h3C, 1, "R7 resumed program data");
    rd(0, 2, 8'hFF, 1, "R8 ignored program data");

    // resume with nothing suspended
    cmd(OP_RESUME, 1, 0, 8'h00, 2'b01);
    chk(plane_busy_o == 0, "R9 stray resume", plane_busy_o, 0);
    chk(status_o == 8'h80, "R9 status after stray resume", status_o, 8'h80);

    // read-reset is inert
    bcyc[3] = 0;
    cmd(OP_PROG, 3, 0, 8'h81, 2'b01);
    cmd(OP_RDRST, 3, 0, 8'h00, 2'b01);
    chk(plane_busy_o == 4'b1000, "R10 op continues", plane_busy_o, 4'b1000);
    wait_idle();
    chk(bcyc[3] == TP, "R10 duration unchanged", bcyc[3], TP);
    rd(3, 0, 8'h81, 1, "R10 data after read-reset");
    cmd(OP_RDRST, 0, 0, 8'h00, 2'b01);
    chk(status_o == 8'h80, "R10 idle status unchanged", status_o, 8'h80);

    // fast erase
    bcyc[3] = 0;
    cmd(OP_ERASE, 3, 0, 8'h00, 2'b11);
    wait_idle();
    chk(bcyc[3] == TEF, "R4 fast erase cycles", bcyc[3], TEF);
    rd(3, 0, 8'hFF, 1, "R4 fast erase data");

    // second suspend refused
    bcyc[0] = 0; bcyc[1] = 0;
    cmd(OP_PROG, 0, 3, 8'h11, 2'b01);
    cmd(OP_SUSP, 0, 0, 8'h00, 2'b01);
    cmd(OP_PROG, 1, 0, 8'h22, 2'b01);
    cmd(OP_SUSP, 1, 0, 8'h00, 2'b01);
    chk(plane_busy_o == 4'b0010, "R8 second suspend ignored", plane_busy_o, 4'b0010);
    wait_idle();
    chk(bcyc[1] == TP, "R8 unsuspended op cycles", bcyc[1], TP);
    cmd(OP_RESUME, 0, 0, 8'h00, 2'b01);
    wait_idle();
    chk(bcyc[0] == TP, "R7 early suspend total", bcyc[0], TP);
    rd(0, 3, 8'h11, 1, "R7 data after resume");
    rd(1, 0, 8'h22, 1, "R8 data of other program");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule